// File: doc/BRIEF.md
# Symbol-Level Device-Failure ECC Codec

This block protects a 128-bit memory word with 16 check bits so that the complete loss of one memory device can be repaired. The word is cut into 8-bit symbols, one symbol per device. The code is a two-check-symbol Reed-Solomon code over GF(2^8). A device that returns garbage therefore corrupts exactly one symbol, and the read path repairs that symbol whatever its bit pattern.

The write side is combinational. It takes the data word and the access address and returns the two check symbols to be stored beside the data. The address is folded into one virtual symbol. That symbol enters both check computations but is never stored, so a word fetched from the wrong location shows up as an error.

The read side takes a word, its stored check bits, its address and an optional erasure marker through a valid/ready handshake. One clock after acceptance it returns the data together with a classification: clean, corrected, or uncorrectable. A repair is applied to the returned copy only. The address of the most recent uncorrectable read is held on a separate output.

Top module: `sgc_codec`

## Requirements
- R1: The symbol and field conventions are as follows. Data symbol i is `wr_data[8i+7:8i]` and has weight α^i. Check bits `[7:0]` form symbol 16 with weight α^16, and check bits `[15:8]` form symbol 17 with weight α^17. The address symbol is the XOR of all address bytes and has weight α^18. The field is GF(2^8) with polynomial 0x11D and α = 0x02. `wr_check` is such that both the plain XOR and the α-weighted XOR of all 19 symbols (address symbol included) are zero.
- R2: A read whose syndromes are both zero returns the data unchanged, with both flags low and `out_pos` = 0, one clock after acceptance.
- R3: If exactly one data symbol differs from its stored value, by any non-zero pattern, the read returns the original data with `out_corrected` = 1 and `out_pos` set to that symbol's index (0..15).
- R4: If only one check symbol is damaged, the data is returned unchanged with `out_corrected` = 1 and `out_pos` = 16 or 17.
- R5: If two symbols are damaged by the same non-zero pattern, the read is flagged `out_uncorrectable` = 1 with `out_pos` = 0, and the raw data is returned unmodified. The two flags are never both high.
- R6: A read presented with an address whose folded symbol differs from the one used at write time is flagged uncorrectable.
- R7: When `erase_en` = 1 and `erase_pos` < 18, a single error at that position is repaired without locating it, and `out_pos` = `erase_pos`. An erasure with no error reads as clean.
- R8: In erasure mode, damage in any symbol other than the erased one is flagged uncorrectable, whether or not the erased symbol is also damaged.
- R9: An `erase_pos` of 18 or above is ignored, and the read is decoded as if `erase_en` were low.
- R10: `fail_addr` takes the address of each accepted uncorrectable read and keeps its value across all other reads.
- R11: `rd_ready` equals `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, the result and its flags stay unchanged.
- R12: After reset, `out_valid`, both flags, `out_pos` and `fail_addr` are zero and `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 128 | Data word to encode |
| wr_addr | input | 32 | Address the word is written to |
| wr_check | output | 16 | Check symbols to store with the word |
| rd_valid | input | 1 | Read word presented |
| rd_ready | output | 1 | Read word accepted this cycle when valid |
| rd_data | input | 128 | Data as read from memory |
| rd_check | input | 16 | Check bits as read from memory |
| rd_addr | input | 32 | Address the word was read from |
| erase_en | input | 1 | Treat `erase_pos` as a known-failed device |
| erase_pos | input | 5 | Symbol index of the failed device |
| out_valid | output | 1 | Decoded result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Data after any repair |
| out_corrected | output | 1 | One symbol was repaired |
| out_uncorrectable | output | 1 | Damage beyond repair was detected |
| out_pos | output | 5 | Index of the repaired symbol |
| fail_addr | output | 32 | Address of the last uncorrectable read |

## Verification
Every encoded word is checked against an independent syndrome evaluation in the bench. Reads are then driven with injected damage of several kinds:
- Damage patterns of a single bit and of a whole byte on first, middle and last data symbols separate locating from mere detection.
- Check-only damage separates a check-symbol repair from a data repair.
- Equal-valued double damage and address mismatches must land in the uncorrectable class.
- Erasure runs cover three cases: a hit on the named symbol, a miss on another symbol, and an out-of-range index. Together they show that the marker overrides the locator only when it is valid.
- A stalled consumer is used to confirm that the result holds and that input acceptance stops.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   localparam int SYM_W = 8;
   localparam logic [SYM_W-1:0] FIELD_TAPS = 8'h1D;

   typedef logic [SYM_W-1:0] sym_t;

   typedef enum logic [1:0] {
      VD_CLEAN = 2'd0,
      VD_FIX   = 2'd1,
      VD_FAIL  = 2'd2
   } verdict_e;

   function automatic sym_t gf_xtime(input sym_t a);
      return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_TAPS : '0);
   endfunction

   function automatic sym_t gf_mul(input sym_t a, input sym_t b);
      sym_t acc;
      sym_t sh;
      acc = '0;
      sh  = a;
      for (int k = 0; k < SYM_W; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   function automatic sym_t gf_pow(input int n);
      sym_t r;
      r = 8'h01;
      for (int k = 0; k < n; k++) r = gf_xtime(r);
      return r;
   endfunction

   function automatic sym_t gf_inv(input sym_t a);
      sym_t r;
      r = 8'h01;
      for (int k = 0; k < 254; k++) r = gf_mul(r, a);
      return r;
   endfunction

endpackage

// File: rtl/sgc_addr_fold.sv
module sgc_addr_fold
   import sgc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output sym_t              folded
);

   localparam int N_CHUNK = (ADDR_W + SYM_W - 1) / SYM_W;
   localparam int PAD_W   = N_CHUNK * SYM_W;

   logic [PAD_W-1:0] padded;
   sym_t             chunk [N_CHUNK];

   assign padded = PAD_W'(addr);

   generate
      for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
         assign chunk[c] = padded[c*SYM_W +: SYM_W];
      end
   endgenerate

   always_comb begin
      folded = '0;
      for (int c = 0; c < N_CHUNK; c++) folded = folded ^ chunk[c];
   end

endmodule

// File: rtl/sgc_encoder.sv
module sgc_encoder
   import sgc_pkg::*;
#(
   parameter int N_DATA = 16
) (
   input  logic [N_DATA*SYM_W-1:0] data,
   input  sym_t                    addr_sym,
   output sym_t                    chk_lo,
   output sym_t                    chk_hi
);

   localparam sym_t W_LO = gf_pow(N_DATA);
   localparam sym_t W_HI = gf_pow(N_DATA + 1);
   localparam sym_t W_AD = gf_pow(N_DATA + 2);
   localparam sym_t K_SOLVE = gf_inv(W_LO ^ W_HI);

   sym_t plain [N_DATA];
   sym_t scaled [N_DATA];
   sym_t sum_p;
   sym_t sum_w;

   generate
      for (genvar i = 0; i < N_DATA; i++) begin : g_sym
         localparam sym_t W_I = gf_pow(i);
         assign plain[i]  = data[i*SYM_W +: SYM_W];
         assign scaled[i] = gf_mul(plain[i], W_I);
      end
   endgenerate

   always_comb begin
      sum_p = addr_sym;
      sum_w = gf_mul(addr_sym, W_AD);
      for (int i = 0; i < N_DATA; i++) begin
         sum_p = sum_p ^ plain[i];
         sum_w = sum_w ^ scaled[i];
      end
   end

   // lo + hi cancels sum_p; W_LO*lo + W_HI*hi cancels sum_w
   assign chk_lo = gf_mul(sum_w ^ gf_mul(sum_p, W_HI), K_SOLVE);
   assign chk_hi = sum_p ^ chk_lo;

endmodule

// File: rtl/sgc_syndrome.sv
module sgc_syndrome
   import sgc_pkg::*;
#(
   parameter int N_DATA = 16
) (
   input  logic [N_DATA*SYM_W-1:0] data,
   input  logic [2*SYM_W-1:0]      check,
   input  sym_t                    addr_sym,
   output sym_t                    s0,
   output sym_t                    s1
);

   localparam sym_t W_LO = gf_pow(N_DATA);
   localparam sym_t W_HI = gf_pow(N_DATA + 1);

   sym_t ref_lo;
   sym_t ref_hi;
   sym_t diff_lo;
   sym_t diff_hi;

   sgc_encoder #(.N_DATA(N_DATA)) u_recalc (
      .data     (data),
      .addr_sym (addr_sym),
      .chk_lo   (ref_lo),
      .chk_hi   (ref_hi)
   );

   assign diff_lo = check[SYM_W-1:0]       ^ ref_lo;
   assign diff_hi = check[2*SYM_W-1:SYM_W] ^ ref_hi;
   assign s0      = diff_lo ^ diff_hi;
   assign s1      = gf_mul(diff_lo, W_LO) ^ gf_mul(diff_hi, W_HI);

endmodule

// File: rtl/sgc_locator.sv
module sgc_locator
   import sgc_pkg::*;
#(
   parameter int N_SYM    = 18,
   parameter int POS_W    = 5,
   parameter bit ERASE_EN = 1'b1
) (
   input  sym_t             s0,
   input  sym_t             s1,
   input  logic             erase_en,
   input  logic [POS_W-1:0] erase_pos,
   output verdict_e         verdict,
   output logic [POS_W-1:0] pos
);

   sym_t             prod [N_SYM];
   logic [N_SYM-1:0] hit;
   logic [POS_W-1:0] hit_pos;
   logic             erase_live;
   sym_t             resid;

   generate
      for (genvar j = 0; j < N_SYM; j++) begin : g_cand
         localparam sym_t W_J = gf_pow(j);
         assign prod[j] = gf_mul(s0, W_J);
         assign hit[j]  = (s0 != '0) && (s1 == prod[j]);
      end
   endgenerate

   always_comb begin
      hit_pos = '0;
      for (int j = N_SYM - 1; j >= 0; j--) begin
         if (hit[j]) hit_pos = POS_W'(j);
      end
   end

   generate
      if (ERASE_EN) begin : g_erase
         sym_t sel;
         always_comb begin
            sel = '0;
            for (int j = 0; j < N_SYM; j++) begin
               if (erase_pos == POS_W'(j)) sel = prod[j];
            end
         end
         assign erase_live = erase_en && (erase_pos < POS_W'(N_SYM));
         assign resid      = s1 ^ sel;
      end else begin : g_no_erase
         assign erase_live = 1'b0;
         assign resid      = '0;
      end
   endgenerate

   always_comb begin
      verdict = VD_CLEAN;
      pos     = '0;
      if ((s0 == '0) && (s1 == '0)) begin
         verdict = VD_CLEAN;
      end else if (erase_live) begin
         if ((s0 != '0) && (resid == '0)) begin
            verdict = VD_FIX;
            pos     = erase_pos;
         end else begin
            verdict = VD_FAIL;
         end
      end else if (|hit) begin
         verdict = VD_FIX;
         pos     = hit_pos;
      end else begin
         verdict = VD_FAIL;
      end
   end

endmodule

// File: rtl/sgc_patch.sv
module sgc_patch
   import sgc_pkg::*;
#(
   parameter int N_DATA = 16,
   parameter int POS_W  = 5
) (
   input  logic [N_DATA*SYM_W-1:0] data_in,
   input  logic                    fix_en,
   input  logic [POS_W-1:0]        fix_pos,
   input  sym_t                    fix_val,
   output logic [N_DATA*SYM_W-1:0] data_out
);

   generate
      for (genvar i = 0; i < N_DATA; i++) begin : g_lane
         logic here;
         assign here = fix_en && (fix_pos == POS_W'(i));
         assign data_out[i*SYM_W +: SYM_W] =
            data_in[i*SYM_W +: SYM_W] ^ (here ? fix_val : '0);
      end
   endgenerate

endmodule

// File: rtl/sgc_codec.sv
module sgc_codec
   import sgc_pkg::*;
#(
   parameter int DATA_W   = 128,
   parameter int ADDR_W   = 32,
   parameter bit ERASE_EN = 1'b1,
   localparam int N_DATA  = DATA_W / SYM_W,
   localparam int N_SYM   = N_DATA + 2,
   localparam int POS_W   = $clog2(N_SYM + 1),
   localparam int CHK_W   = 2 * SYM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [CHK_W-1:0]  wr_check,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_check,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              erase_en,
   input  logic [POS_W-1:0]  erase_pos,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_corrected,
   output logic              out_uncorrectable,
   output logic [POS_W-1:0]  out_pos,
   output logic [ADDR_W-1:0] fail_addr
);

   generate
      if (DATA_W % SYM_W != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of symbols");
      end
      if (N_SYM + 1 > 255) begin : g_bad_len
         $error("codeword plus address symbol exceeds field order");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   // write side
   sym_t wr_asym;
   sym_t wr_lo;
   sym_t wr_hi;

   sgc_addr_fold #(.ADDR_W(ADDR_W)) u_wfold (
      .addr   (wr_addr),
      .folded (wr_asym)
   );

   sgc_encoder #(.N_DATA(N_DATA)) u_enc (
      .data     (wr_data),
      .addr_sym (wr_asym),
      .chk_lo   (wr_lo),
      .chk_hi   (wr_hi)
   );

   assign wr_check = {wr_hi, wr_lo};

   // read side
   sym_t             rd_asym;
   sym_t             s0;
   sym_t             s1;
   verdict_e         verdict;
   logic [POS_W-1:0] loc_pos;
   logic [DATA_W-1:0] fixed_data;
   logic             accept;

   sgc_addr_fold #(.ADDR_W(ADDR_W)) u_rfold (
      .addr   (rd_addr),
      .folded (rd_asym)
   );

   sgc_syndrome #(.N_DATA(N_DATA)) u_syn (
      .data     (rd_data),
      .check    (rd_check),
      .addr_sym (rd_asym),
      .s0       (s0),
      .s1       (s1)
   );

   sgc_locator #(.N_SYM(N_SYM), .POS_W(POS_W), .ERASE_EN(ERASE_EN)) u_loc (
      .s0        (s0),
      .s1        (s1),
      .erase_en  (erase_en),
      .erase_pos (erase_pos),
      .verdict   (verdict),
      .pos       (loc_pos)
   );

   sgc_patch #(.N_DATA(N_DATA), .POS_W(POS_W)) u_patch (
      .data_in  (rd_data),
      .fix_en   (verdict == VD_FIX),
      .fix_pos  (loc_pos),
      .fix_val  (s0),
      .data_out (fixed_data)
   );

   assign rd_ready = !out_valid || out_ready;
   assign accept   = rd_valid && rd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid         <= 1'b0;
         out_data          <= '0;
         out_corrected     <= 1'b0;
         out_uncorrectable <= 1'b0;
         out_pos           <= '0;
         fail_addr         <= '0;
      end else begin
         if (rd_ready) out_valid <= rd_valid;
         if (accept) begin
            out_data          <= fixed_data;
            out_corrected     <= (verdict == VD_FIX);
            out_uncorrectable <= (verdict == VD_FAIL);
            out_pos           <= (verdict == VD_FIX) ? loc_pos : '0;
            if (verdict == VD_FAIL) fail_addr <= rd_addr;
         end
      end
   end

   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (s0 == '0) && (s1 == '0) |=>
         !out_corrected && !out_uncorrectable && (out_data == $past(rd_data))); // R2

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_corrected |-> (out_pos < POS_W'(N_SYM))); // R3

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_corrected && out_uncorrectable)); // R5

   AST_ERASE_POS: assert property (@(posedge clk) disable iff (!rst_n)
      accept && erase_en && (erase_pos < POS_W'(N_SYM)) && (verdict == VD_FIX) |=>
         (out_pos == $past(erase_pos))); // R7

   AST_FAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fail_addr) |-> out_valid && out_uncorrectable); // R10

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=>
         out_valid && $stable(out_data) && $stable(out_pos) && $stable(out_corrected)); // R11

endmodule

// File: tb/tb_sgc_codec.sv
`timescale 1ns/1ps
module tb_sgc_codec;

   localparam int DW = 128;
   localparam int AW = 32;
   localparam int PW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_check;
   logic          rd_valid = 1'b0;
   logic          rd_ready;
   logic [DW-1:0] rd_data = '0;
   logic [15:0]   rd_check = '0;
   logic [AW-1:0] rd_addr = '0;
   logic          erase_en = 1'b0;
   logic [PW-1:0] erase_pos = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic          out_corrected;
   logic          out_uncorrectable;
   logic [PW-1:0] out_pos;
   logic [AW-1:0] fail_addr;

   sgc_codec dut (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_data), .wr_addr(wr_addr), .wr_check(wr_check),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .rd_check(rd_check), .rd_addr(rd_addr),
      .erase_en(erase_en), .erase_pos(erase_pos),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable),
      .out_pos(out_pos), .fail_addr(fail_addr)
   );

   int total = 0;
   int bad = 0;

   typedef struct {
      logic [DW-1:0] d;
      logic          c;
      logic          u;
      logic [PW-1:0] p;
      logic [AW-1:0] f;
      int            req;
   } exp_t;

   exp_t q[$];
   logic [AW-1:0] model_fail = '0;

   task automatic check(input bit ok, input int req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // bench-side field arithmetic
   function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] prod;
      prod = '0;
      for (int k = 0; k < 8; k++) if (b[k]) prod = prod ^ (16'(a) << k);
      for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h011D << (k - 8));
      return prod[7:0];
   endfunction

   function automatic logic [7:0] bpow(input int n);
      logic [7:0] r;
      r = 8'h01;
      for (int k = 0; k < n; k++) r = bmul(r, 8'h02);
      return r;
   endfunction

   function automatic logic [15:0] bsyn(input logic [DW-1:0] d, input logic [15:0] c,
                                        input logic [AW-1:0] a);
      logic [7:0] x0, x1, sym, asym;
      asym = a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
      x0 = '0;
      x1 = '0;
      for (int i = 0; i < 19; i++) begin
         if (i < 16)       sym = d[i*8 +: 8];
         else if (i == 16) sym = c[7:0];
         else if (i == 17) sym = c[15:8];
         else              sym = asym;
         x0 = x0 ^ sym;
         x1 = x1 ^ bmul(sym, bpow(i));
      end
      return {x1, x0};
   endfunction

   function automatic logic [DW-1:0] mkword(input int seed);
      logic [31:0] s;
      logic [DW-1:0] w;
      s = 32'(seed) * 32'd2654435761 + 32'd12345;
      for (int k = 0; k < 4; k++) begin
         s = s * 32'd1103515245 + 32'd12345;
         w[k*32 +: 32] = s;
      end
      return w;
   endfunction

   function automatic logic [DW-1:0] hitd(input logic [DW-1:0] d, input int pos,
                                          input logic [7:0] v);
      return d ^ (DW'(v) << (pos * 8));
   endfunction

   task automatic encode(input logic [DW-1:0] d, input logic [AW-1:0] a,
                         output logic [15:0] ck);
      wr_data = d;
      wr_addr = a;
      #1;
      ck = wr_check;
      // R1: both syndromes vanish, address symbol included
      check(bsyn(d, ck, a) == 16'h0000, 1, "encode syndrome", DW'(bsyn(d, ck, a)), '0);
   endtask

   task automatic send(input logic [DW-1:0] d, input logic [15:0] ck, input logic [AW-1:0] a,
                       input logic ee, input logic [PW-1:0] ep,
                       input logic [DW-1:0] ed, input logic ec, input logic eu,
                       input logic [PW-1:0] epos, input int req);
      exp_t e;
      @(negedge clk);
      rd_valid  = 1'b1;
      rd_data   = d;
      rd_check  = ck;
      rd_addr   = a;
      erase_en  = ee;
      erase_pos = ep;
      #1;
      while (!rd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      if (eu) model_fail = a;
      e.d = ed; e.c = ec; e.u = eu; e.p = epos; e.f = model_fail; e.req = req;
      q.push_back(e);
      #1;
      rd_valid = 1'b0;
      erase_en = 1'b0;
   endtask

   // cycle monitor: compares against the reference queue every clock
   logic [DW-1:0] prev_d = '0;
   logic [PW-1:0] prev_p = '0;
   bit            prev_stall = 1'b0;
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         check(rd_ready == (!out_valid || out_ready), 11, "ready rule",
               DW'(rd_ready), DW'(!out_valid || out_ready));
         if (prev_stall)
            check(out_valid && out_data == prev_d && out_pos == prev_p, 11, "hold while stalled",
                  out_data, prev_d);
         if (out_valid && out_ready) begin
            if (q.size() == 0) begin
               check(1'b0, 2, "unexpected output", DW'(out_valid), '0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(out_data == e.d, e.req, "data", out_data, e.d);
               check(out_corrected == e.c, e.req, "corrected", DW'(out_corrected), DW'(e.c));
               check(out_uncorrectable == e.u, e.req, "uncorrectable",
                     DW'(out_uncorrectable), DW'(e.u));
               check(out_pos == e.p, e.req, "position", DW'(out_pos), DW'(e.p));
               check(fail_addr == e.f, 10, "fail address", DW'(fail_addr), DW'(e.f)); // R10
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_d     = out_data;
         prev_p     = out_pos;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] w;
      logic [DW-1:0] w2;
      logic [15:0]   ck;
      logic [15:0]   ck2;
      logic [AW-1:0] a;

      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      check(out_valid == 1'b0, 12, "reset valid", DW'(out_valid), '0);
      check(!out_corrected && !out_uncorrectable, 12, "reset flags",
            DW'({out_corrected, out_uncorrectable}), '0);
      check(out_pos == '0 && fail_addr == '0, 12, "reset pos/addr", DW'(fail_addr), '0);
      check(rd_ready == 1'b1, 12, "reset ready", DW'(rd_ready), DW'(1));
      @(negedge clk);
      rst_n = 1'b1;

      // R1: encoding under several patterns
      encode('0, '0, ck);
      encode({DW{1'b1}}, 32'hFFFF_FFFF, ck);
      encode(mkword(1), 32'h0000_1000, ck);
      encode(mkword(2), 32'h8765_4321, ck);

      // R2: clean reads
      for (int n = 0; n < 3; n++) begin
         w = mkword(10 + n);
         a = 32'h0001_0000 + 32'(n * 64);
         encode(w, a, ck);
         send(w, ck, a, 1'b0, '0, w, 1'b0, 1'b0, '0, 2); // R2
      end

      // R3: whole-symbol and single-bit damage on data symbols
      w = mkword(20); a = 32'h0000_2040; encode(w, a, ck);
      send(hitd(w, 0, 8'h01), ck, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd0, 3);  // R3
      send(hitd(w, 7, 8'hFF), ck, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd7, 3);  // R3
      send(hitd(w, 15, 8'h5A), ck, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd15, 3); // R3

      // R4: damage confined to a check symbol
      send(w, ck ^ 16'h00A5, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd16, 4); // R4
      send(w, ck ^ 16'h3C00, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd17, 4); // R4

      // R5: two symbols with equal damage
      w2 = hitd(hitd(w, 2, 8'h33), 9, 8'h33);
      send(w2, ck, a, 1'b0, '0, w2, 1'b0, 1'b1, '0, 5); // R5
      w2 = hitd(w, 3, 8'h77);
      send(w2, ck ^ 16'h7700, 32'h0000_2040, 1'b0, '0, w2, 1'b0, 1'b1, '0, 5); // R5

      // R6: read from a location other than the one written
      send(w, ck, a ^ 32'h0000_0001, 1'b0, '0, w, 1'b0, 1'b1, '0, 6); // R6
      send(w, ck, a ^ 32'h0400_0000, 1'b0, '0, w, 1'b0, 1'b1, '0, 6); // R6

      // R10: fail address holds across later good reads
      send(w, ck, a, 1'b0, '0, w, 1'b0, 1'b0, '0, 10); // R10

      // R7: erasure repairs the named symbol
      w = mkword(30); a = 32'h00AB_0000; encode(w, a, ck);
      send(hitd(w, 5, 8'hC3), ck, a, 1'b1, 5'd5, w, 1'b1, 1'b0, 5'd5, 7); // R7
      send(w, ck ^ 16'h0011, a, 1'b1, 5'd16, w, 1'b1, 1'b0, 5'd16, 7);  // R7
      send(w, ck, a, 1'b1, 5'd9, w, 1'b0, 1'b0, '0, 7);                 // R7

      // R8: erasure plus damage elsewhere
      w2 = hitd(hitd(w, 5, 8'h21), 11, 8'h90);
      send(w2, ck, a, 1'b1, 5'd5, w2, 1'b0, 1'b1, '0, 8); // R8
      w2 = hitd(w, 12, 8'h04);
      send(w2, ck, a, 1'b1, 5'd3, w2, 1'b0, 1'b1, '0, 8); // R8

      // R9: out-of-range erasure index is ignored
      send(hitd(w, 4, 8'h81), ck, a, 1'b1, 5'd20, w, 1'b1, 1'b0, 5'd4, 9); // R9
      send(hitd(w, 14, 8'h10), ck, a, 1'b1, 5'd18, w, 1'b1, 1'b0, 5'd14, 9); // R9

      // R11: stalled consumer
      w = mkword(40); a = 32'h0000_7700; encode(w, a, ck);
      w2 = mkword(41); encode(w2, a + 32'h40, ck2);
      @(negedge clk);
      out_ready = 1'b0;
      send(hitd(w, 6, 8'h0F), ck, a, 1'b0, '0, w, 1'b1, 1'b0, 5'd6, 11); // R11
      fork
         send(w2, ck2, a + 32'h40, 1'b0, '0, w2, 1'b0, 1'b0, '0, 11); // R11
         begin
            repeat (4) @(negedge clk);
            check(out_valid == 1'b1 && rd_ready == 1'b0, 11, "stall blocks input",
                  DW'({out_valid, rd_ready}), DW'(2'b10));
            out_ready = 1'b1;
         end
      join

      repeat (6) @(negedge clk);
      #1;
      check(q.size() == 0, 2, "all results delivered", DW'(q.size()), '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule